// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block keeps the fault confinement bookkeeping of a CAN node. A receive error count and a transmit error count change only when the frame-level bitstream logic sends a one-cycle increment or decrement strobe. Each increment carries a step selector that picks a step of one or a step of eight. From the two counts the block derives one of three confinement modes: error-active, error-passive or bus-off. It shows that mode on two flags.

Bus-off is held in a register. Once the node is in bus-off it ignores all counter commands. It counts pulses from the bit-level logic, one pulse for each run of eleven recessive bits it observes. When the programmed number of pulses has been seen, both counts clear and the node returns to error-active. A synchronous reset gives the same clean start.

Top module: `can_fault_conf`

## Requirements
- R1: While `rst` is high at a clock edge, both counts become 0 after that edge, and `err_passive` and `bus_off` become 0.
- R2: Outside bus-off, an increment strobe adds 1 to its count when the step select is 0, and adds 8 when it is 1. The new value is visible after the next clock edge.
- R3: Outside bus-off, a decrement strobe subtracts 1 from its count. A count of 0 stays at 0.
- R4: When the increment and decrement strobes of the same count are high in the same cycle, the increment is applied and the decrement is ignored.
- R5: The receive count saturates at 255. Further increments leave it at 255, and receive errors alone never cause bus-off.
- R6: `err_passive` is 1 exactly when `bus_off` is 0 and either count is above 127.
- R7: `bus_off` rises after the same edge at which the transmit count first exceeds 255. `err_passive` and `bus_off` are never high together.
- R8: While `bus_off` is high, every increment and decrement strobe is ignored, and both counts hold.
- R9: While in bus-off, the 128th `idle11` pulse clears both counts and drops `bus_off` at that clock edge. This takes precedence over any counter strobe in the same cycle. After 127 pulses the node is still in bus-off.
- R10: `idle11` pulses outside bus-off have no effect. They neither change the outputs nor count toward a later recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rec_up | input | 1 | Receive count increment strobe |
| rec_up8 | input | 1 | Step select for `rec_up` (0: 1, 1: 8) |
| rec_dn | input | 1 | Receive count decrement strobe |
| tec_up | input | 1 | Transmit count increment strobe |
| tec_up8 | input | 1 | Step select for `tec_up` (0: 1, 1: 8) |
| tec_dn | input | 1 | Transmit count decrement strobe |
| idle11 | input | 1 | One pulse per 11 consecutive recessive bits seen |
| rec_cnt | output | 8 | Receive error count |
| tec_cnt | output | 9 | Transmit error count |
| err_passive | output | 1 | Node is error-passive |
| bus_off | output | 1 | Node is bus-off |

## Verification
The two functions that collide are the completion of recovery and a counter strobe. If the final `idle11` pulse arrives in the same cycle as an increment, the clear must win. The directed part of the bench drives the 128th pulse together with a step-of-eight receive increment and expects both counts to read zero afterwards. The random part keeps pulses and strobes active at the same time through many bus-off episodes, and it compares every cycle against a bench model in which recovery takes priority.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
   typedef enum logic [1:0] {
      FC_ACTIVE  = 2'd0,
      FC_PASSIVE = 2'd1,
      FC_BUSOFF  = 2'd2
   } fc_mode_e;
endpackage

// File: rtl/can_fc_counter.sv
module can_fc_counter #(
   parameter int W        = 8,
   parameter int BIG_STEP = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         hold,
   input  logic         up,
   input  logic         up_big,
   input  logic         dn,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cnt_nxt
);
   localparam logic [W:0] STEP_B = (W+1)'(BIG_STEP);
   localparam logic [W:0] STEP_S = (W+1)'(1);

   if (BIG_STEP < 1 || BIG_STEP >= 2**W) begin : g_bad_step
      $error("can_fc_counter: BIG_STEP out of range");
   end

   logic [W:0]   sum;
   logic [W-1:0] inc_val;

   assign sum = {1'b0, cnt} + (up_big ? STEP_B : STEP_S);

   if (SATURATE) begin : g_sat
      assign inc_val = sum[W] ? '1 : sum[W-1:0];
   end else begin : g_wrap
      assign inc_val = sum[W-1:0];
   end

   always_comb begin
      if (clr)                     cnt_nxt = '0;
      else if (hold)               cnt_nxt = cnt;
      else if (up)                 cnt_nxt = inc_val;
      else if (dn && cnt != '0)    cnt_nxt = cnt - W'(1);
      else                         cnt_nxt = cnt;
   end

   always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt_nxt;
   end
endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
   parameter int RECOV_N = 128
) (
   input  logic clk,
   input  logic rst,
   input  logic active,
   input  logic pulse,
   output logic done
);
   localparam int CW = (RECOV_N > 2) ? $clog2(RECOV_N) : 1;
   localparam logic [CW-1:0] LAST = CW'(RECOV_N - 1);

   if (RECOV_N < 2) begin : g_bad_n
      $error("can_fc_recovery: RECOV_N must be at least 2");
   end

   logic [CW-1:0] seen;

   assign done = active && pulse && (seen == LAST);

   always_ff @(posedge clk) begin
      if (rst || !active || done) seen <= '0;
      else if (pulse)             seen <= seen + CW'(1);
   end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
   import can_fc_pkg::*;
#(
   parameter int REC_W       = 8,
   parameter int TEC_W       = 9,
   parameter int PASSIVE_LIM = 127,
   parameter int BUSOFF_LIM  = 255,
   parameter int BIG_STEP    = 8,
   parameter int RECOV_N     = 128
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rec_up,
   input  logic             rec_up8,
   input  logic             rec_dn,
   input  logic             tec_up,
   input  logic             tec_up8,
   input  logic             tec_dn,
   input  logic             idle11,
   output logic [REC_W-1:0] rec_cnt,
   output logic [TEC_W-1:0] tec_cnt,
   output logic             err_passive,
   output logic             bus_off
);
   localparam logic [REC_W-1:0] REC_PL = REC_W'(PASSIVE_LIM);
   localparam logic [TEC_W-1:0] TEC_PL = TEC_W'(PASSIVE_LIM);
   localparam logic [TEC_W-1:0] TEC_BL = TEC_W'(BUSOFF_LIM);

   if (BUSOFF_LIM + BIG_STEP > 2**TEC_W - 1) begin : g_bad_tec
      $error("can_fault_conf: TEC_W too narrow for BUSOFF_LIM");
   end
   if (PASSIVE_LIM >= 2**REC_W - 1 || PASSIVE_LIM >= BUSOFF_LIM) begin : g_bad_lim
      $error("can_fault_conf: PASSIVE_LIM out of range");
   end

   logic             bo_q;
   logic             recov_done;
   logic [REC_W-1:0] rec_nxt;
   logic [TEC_W-1:0] tec_nxt;
   fc_mode_e         mode;

   can_fc_counter #(.W(REC_W), .BIG_STEP(BIG_STEP), .SATURATE(1'b1)) u_rec (
      .clk(clk), .rst(rst), .clr(recov_done), .hold(bo_q),
      .up(rec_up), .up_big(rec_up8), .dn(rec_dn),
      .cnt(rec_cnt), .cnt_nxt(rec_nxt)
   );

   can_fc_counter #(.W(TEC_W), .BIG_STEP(BIG_STEP), .SATURATE(1'b1)) u_tec (
      .clk(clk), .rst(rst), .clr(recov_done), .hold(bo_q),
      .up(tec_up), .up_big(tec_up8), .dn(tec_dn),
      .cnt(tec_cnt), .cnt_nxt(tec_nxt)
   );

   can_fc_recovery #(.RECOV_N(RECOV_N)) u_recov (
      .clk(clk), .rst(rst), .active(bo_q), .pulse(idle11), .done(recov_done)
   );

   always_ff @(posedge clk) begin
      if (rst || recov_done)            bo_q <= 1'b0;
      else if (!bo_q && tec_nxt > TEC_BL) bo_q <= 1'b1;
   end

   always_comb begin
      if (bo_q)                                    mode = FC_BUSOFF;
      else if (rec_cnt > REC_PL || tec_cnt > TEC_PL) mode = FC_PASSIVE;
      else                                         mode = FC_ACTIVE;
   end

   assign err_passive = (mode == FC_PASSIVE);
   assign bus_off     = (mode == FC_BUSOFF);
endmodule

// File: rtl/can_fc_chk.sv
module can_fc_chk #(
   parameter int REC_W       = 8,
   parameter int TEC_W       = 9,
   parameter int PASSIVE_LIM = 127,
   parameter int BUSOFF_LIM  = 255
) (
   input logic             clk,
   input logic             rst,
   input logic             rec_up,
   input logic             rec_dn,
   input logic             idle11,
   input logic [REC_W-1:0] rec_cnt,
   input logic [TEC_W-1:0] tec_cnt,
   input logic             err_passive,
   input logic             bus_off
);
   localparam logic [REC_W-1:0] REC_MAX = '1;
   localparam logic [TEC_W-1:0] TEC_BL  = TEC_W'(BUSOFF_LIM);

   p_reset_r1: assert property (@(posedge clk)
      rst |=> (rec_cnt == '0 && tec_cnt == '0 && !err_passive && !bus_off));

   p_dec_floor_r3: assert property (@(posedge clk) disable iff (rst)
      (!bus_off && rec_cnt == '0 && rec_dn && !rec_up) |=> rec_cnt == '0);

   p_rec_sat_r5: assert property (@(posedge clk) disable iff (rst)
      (!bus_off && rec_cnt == REC_MAX && rec_up) |=> rec_cnt == REC_MAX);

   p_excl_r7: assert property (@(posedge clk) disable iff (rst)
      !(err_passive && bus_off));

   p_entry_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_off) |-> tec_cnt > TEC_BL);

   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (bus_off && !idle11) |=> ($stable(rec_cnt) && $stable(tec_cnt) && bus_off));

   p_leave_r9: assert property (@(posedge clk) disable iff (rst)
      $fell(bus_off) |-> (rec_cnt == '0 && tec_cnt == '0));
endmodule

bind can_fault_conf can_fc_chk #(
   .REC_W(REC_W), .TEC_W(TEC_W), .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
) u_chk (
   .clk(clk), .rst(rst), .rec_up(rec_up), .rec_dn(rec_dn), .idle11(idle11),
   .rec_cnt(rec_cnt), .tec_cnt(tec_cnt), .err_passive(err_passive), .bus_off(bus_off)
);

// File: tb/tb_can_fault_conf.sv
module tb_can_fault_conf;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst;
   logic       rec_up, rec_up8, rec_dn, tec_up, tec_up8, tec_dn, idle11;
   logic [7:0] rec_cnt;
   logic [8:0] tec_cnt;
   logic       err_passive, bus_off;

   int total = 0;
   int bad   = 0;
   int m_rec, m_tec, m_rc;
   bit m_bo;

   always #(CLK_PERIOD/2) clk = ~clk;

   can_fault_conf dut (
      .clk(clk), .rst(rst),
      .rec_up(rec_up), .rec_up8(rec_up8), .rec_dn(rec_dn),
      .tec_up(tec_up), .tec_up8(tec_up8), .tec_dn(tec_dn),
      .idle11(idle11),
      .rec_cnt(rec_cnt), .tec_cnt(tec_cnt),
      .err_passive(err_passive), .bus_off(bus_off)
   );

   function automatic int f_inc(int v, bit big, int maxv);
      int s = v + (big ? 8 : 1);
      return (s > maxv) ? maxv : s;
   endfunction

   function automatic int f_dec(int v);
      return (v > 0) ? v - 1 : 0;
   endfunction

   task automatic check(string req, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   task automatic check_model();
      check("R2 R3 R4 R5 rec", int'(rec_cnt), m_rec);
      check("R2 R3 R4 tec", int'(tec_cnt), m_tec);
      check("R7 R9 bus_off", int'(bus_off), int'(m_bo));
      check("R6 err_passive", int'(err_passive),
            int'(!m_bo && (m_rec > 127 || m_tec > 127)));
   endtask

   // v = {idle11, tec_dn, tec_up8, tec_up, rec_dn, rec_up8, rec_up}
   task automatic cyc(input logic [6:0] v);
      {idle11, tec_dn, tec_up8, tec_up, rec_dn, rec_up8, rec_up} = v;
      if (m_bo) begin
         if (v[6]) begin
            if (m_rc == 127) begin
               m_rec = 0; m_tec = 0; m_bo = 1'b0; m_rc = 0;
            end else m_rc++;
         end
      end else begin
         m_rc = 0;
         if (v[0])      m_rec = f_inc(m_rec, v[1], 255);
         else if (v[2]) m_rec = f_dec(m_rec);
         if (v[3])      m_tec = f_inc(m_tec, v[4], 511);
         else if (v[5]) m_tec = f_dec(m_tec);
         if (m_tec > 255) m_bo = 1'b1;
      end
      @(posedge clk); #1;
      {idle11, tec_dn, tec_up8, tec_up, rec_dn, rec_up8, rec_up} = '0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      {idle11, tec_dn, tec_up8, tec_up, rec_dn, rec_up8, rec_up} = '0;
      repeat (2) @(posedge clk);
      #1;
      rst = 1'b0;
      m_rec = 0; m_tec = 0; m_bo = 1'b0; m_rc = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      do_reset();
      check("R1 rec", int'(rec_cnt), 0);
      check("R1 tec", int'(tec_cnt), 0);
      check("R1 flags", int'({err_passive, bus_off}), 0);

      cyc(7'b0000001);
      check("R2 step1", int'(rec_cnt), 1);
      cyc(7'b0000011);
      check("R2 step8", int'(rec_cnt), 9);
      for (int i = 0; i < 12; i++) cyc(7'b0000100);
      check("R3 floor", int'(rec_cnt), 0);
      cyc(7'b0000101);
      check("R4 inc wins", int'(rec_cnt), 1);
      for (int i = 0; i < 16; i++) cyc(7'b0000011);
      check("R6 passive rec", int'(err_passive), 1);
      check("R6 rec 129", int'(rec_cnt), 129);
      for (int i = 0; i < 16; i++) cyc(7'b0000011);
      check("R5 saturate", int'(rec_cnt), 255);
      check("R5 no busoff", int'(bus_off), 0);
      for (int i = 0; i < 128; i++) cyc(7'b0000100);
      check("R6 rec 127", int'(rec_cnt), 127);
      check("R6 active", int'(err_passive), 0);
      for (int i = 0; i < 200; i++) cyc(7'b1000000);
      check("R10 rec", int'(rec_cnt), 127);
      check("R10 flags", int'({err_passive, bus_off}), 0);
      for (int i = 0; i < 31; i++) cyc(7'b0011000);
      check("R6 tec 248", int'(tec_cnt), 248);
      check("R7 not yet", int'(bus_off), 0);
      cyc(7'b0011000);
      check("R7 tec 256", int'(tec_cnt), 256);
      check("R7 busoff", int'(bus_off), 1);
      check("R7 excl", int'(err_passive), 0);
      for (int i = 0; i < 10; i++) cyc(7'b0100011);
      cyc(7'b0011100);
      check("R8 rec held", int'(rec_cnt), 127);
      check("R8 tec held", int'(tec_cnt), 256);
      for (int i = 0; i < 127; i++) cyc(7'b1000000);
      check("R9 after 127", int'(bus_off), 1);
      cyc(7'b1000011);
      check("R9 rec clear", int'(rec_cnt), 0);
      check("R9 tec clear", int'(tec_cnt), 0);
      check("R9 active", int'({err_passive, bus_off}), 0);

      for (int n = 0; n < 20000; n++) begin
         logic [6:0] v;
         int r;
         r = int'($urandom_range(99));
         v[0] = (r < 25);
         v[1] = $urandom_range(1) == 1;
         v[2] = $urandom_range(99) < 30;
         r = int'($urandom_range(99));
         v[3] = (r < 20);
         v[4] = $urandom_range(1) == 1;
         v[5] = $urandom_range(99) < 30;
         v[6] = $urandom_range(1) == 1;
         cyc(v);
         check_model();
         if (n == 10000) begin
            do_reset();
            check("R1 mid reset", int'({rec_cnt, tec_cnt, err_passive, bus_off}), 0);
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule